// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single management transactions toward an Ethernet PHY over the two-wire management bus. A client presents a command with a one-cycle request strobe. The command carries a read/write flag, a 5-bit PHY address, a register index and 16 bits of write data. The block then produces the serial frame on the management data line while toggling the management clock. For a read, it returns the register contents along with a one-cycle done pulse.

The management clock comes from the system clock through a divider. The parameter `MDC_HALF` gives the number of system clocks in each half period. Each bit period starts with a low phase, in which the line is driven or the PHY is expected to settle. A high phase follows, and its rising edge is where the block captures incoming data. Every frame opens with 33 periods of a driven one. A read continues with a short 16-bit header. The line is then released for 19 clocked periods, of which the middle sixteen are kept. A write continues with a full 32-bit frame and two released idle clocks. A register index with any bit above bit 4 set is refused at once and causes no bus activity.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no transaction is running, `busy`, `done`, `mdc` and `mdio_oe` are all low.
- R2: Every accepted transaction starts with exactly 33 bit periods in which `mdio_oe` is 1 and `mdio_o` is 1.
- R3: A read header follows the preamble as 16 driven bits, MSB first: 1,1, then 0,1, then 1,0, then the PHY address (bit 4 first), then the register index (bit 4 first).
- R4: After the read header, `mdio_oe` is 0 for exactly 19 bit periods. Call the value of `mdio_i` at the rising `mdc` edge of released period k (k = 0..18) s[k]. Then `rdata` = {s[2], s[3], ..., s[17]}, and s[0], s[1] and s[18] are discarded.
- R5: A write frame follows the preamble as 32 driven bits, MSB first: 0,1, then 0,1, then the PHY address, then the register index, then 1,0, then the 16 write data bits.
- R6: After the write frame, `mdio_oe` is 0 for exactly two more bit periods, and the done pulse follows the last of them.
- R7: `mdc` stays low for `MDC_HALF` system clocks and then high for `MDC_HALF` system clocks in each bit period. `mdio_o` and `mdio_oe` change only while `mdc` is low.
- R8: A request whose register index has a bit set above bit 4 produces `done` in the next cycle with no `mdc` edge and no `busy`. For a read, `rdata` is 16'hFFFF.
- R9: For an accepted request, `busy` is 1 from the cycle after the request until the cycle of the done pulse. The done pulse lasts one cycle, and `busy` is 0 during it. With N bit periods, done appears 2·N·MDC_HALF cycles after the request edge.
- R10: A request raised while `busy` is 1 is ignored: the running frame goes on unchanged and only one done pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | One-cycle command strobe |
| wr | input | 1 | 1 = write, 0 = read |
| phy_addr | input | 5 | Target PHY address |
| reg_idx | input | IDX_W | Register index; values above 31 are refused |
| wdata | input | 16 | Data for a write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, valid from the done pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Drive enable for management data |
| mdio_i | input | 1 | Management data in |

## Verification
The bench runs a PHY model that returns a 19-bit response pattern with random turnaround and idle bits. Any off-by-one in the capture window therefore shows up as a shifted or corrupted `rdata`. Each frame is recorded bit by bit at the rising `mdc` edges, and the bench compares the preamble length, the header or frame contents and the released-period count. A design that sent 32 preamble ones, the wrong opcode, or one tail clock too many would fail these comparisons and also miss the exact done cycle. Other tests target refused indices, where a faulty design would toggle `mdc` or return stale data, and a request injected mid-frame, where a faulty design would restart or corrupt the frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_BITS    = 33;
    localparam int RD_HDR_BITS = 16;
    localparam int WR_HDR_BITS = 32;
    localparam int RX_BITS     = 19;
    localparam int TAIL_BITS   = 2;
    localparam int RX_KEEP_LO  = 2;
    localparam int RX_KEEP_HI  = 17;
    localparam int CNT_W       = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_RX,
        ST_TAIL
    } mstate_t;

    typedef struct packed {
        logic        wr;
        logic [4:0]  phy;
        logic [4:0]  regi;
        logic [15:0] wdata;
    } mcmd_t;

    // Driven frame image, left aligned so bit 31 leaves first.
    function automatic logic [31:0] frame_word(mcmd_t c);
        if (c.wr)
            return {2'b01, 2'b01, c.phy, c.regi, 2'b10, c.wdata};
        else
            return {2'b11, 2'b01, 2'b10, c.phy, c.regi, 16'h0000};
    endfunction

    // Index of the final bit period of a phase.
    function automatic logic [CNT_W-1:0] phase_last(mstate_t s, logic wr);
        case (s)
            ST_PRE:  return CNT_W'(PRE_BITS - 1);
            ST_HDR:  return wr ? CNT_W'(WR_HDR_BITS - 1) : CNT_W'(RD_HDR_BITS - 1);
            ST_RX:   return CNT_W'(RX_BITS - 1);
            ST_TAIL: return CNT_W'(TAIL_BITS - 1);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/mdio_tick_gen.sv
module mdio_tick_gen #(
    parameter int MDC_HALF = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic rise_tick,
    output logic fall_tick,
    output logic mdc
);
    localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
    localparam logic [CW-1:0] CMAX = CW'(MDC_HALF - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap      = run && (cnt == CMAX);
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r7_mdc_only_on_tick: assert property (@(posedge clk) disable iff (rst)
        (run && !wrap && $past(run)) |=> $stable(mdc));

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  mcmd_t       cmd,
    input  logic        idx_bad,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdi,
    output mstate_t     state,
    output logic        done,
    output logic [15:0] rdata,
    output logic        mdo,
    output logic        oe
);
    logic [CNT_W-1:0] bitcnt;
    logic [31:0]      sr;
    logic [15:0]      rxsh;
    logic             wr_q;
    logic             last_bit;
    logic             keep_bit;

    assign last_bit = (bitcnt == phase_last(state, wr_q));
    assign keep_bit = (bitcnt >= CNT_W'(RX_KEEP_LO)) && (bitcnt <= CNT_W'(RX_KEEP_HI));
    assign oe       = (state == ST_PRE) || (state == ST_HDR);
    assign mdo      = (state == ST_HDR) ? sr[31] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            done   <= 1'b0;
            rdata  <= '0;
            bitcnt <= '0;
            sr     <= '0;
            rxsh   <= '0;
            wr_q   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == ST_IDLE) begin
                if (req) begin
                    if (idx_bad) begin
                        done <= 1'b1;
                        if (!cmd.wr)
                            rdata <= 16'hFFFF;
                    end else begin
                        wr_q   <= cmd.wr;
                        sr     <= frame_word(cmd);
                        bitcnt <= '0;
                        state  <= ST_PRE;
                    end
                end
            end else begin
                if (rise_tick && state == ST_RX && keep_bit)
                    rxsh <= {rxsh[14:0], mdi};
                if (fall_tick) begin
                    if (state == ST_HDR)
                        sr <= {sr[30:0], 1'b0};
                    if (last_bit) begin
                        bitcnt <= '0;
                        case (state)
                            ST_PRE:  state <= ST_HDR;
                            ST_HDR:  state <= wr_q ? ST_TAIL : ST_RX;
                            ST_RX: begin
                                state <= ST_IDLE;
                                done  <= 1'b1;
                                rdata <= rxsh;
                            end
                            default: begin
                                state <= ST_IDLE;
                                done  <= 1'b1;
                            end
                        endcase
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
            end
        end
    end

    a_r4_released_in_rx: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RX || state == ST_TAIL) |-> !oe);
    a_r2_pre_enters_hdr: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_PRE && state != ST_PRE) |-> state == ST_HDR);

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int MDC_HALF = 25,
    parameter int IDX_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             wr,
    input  logic [4:0]       phy_addr,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [15:0]      wdata,
    output logic             busy,
    output logic             done,
    output logic [15:0]      rdata,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    mstate_t state;
    mcmd_t   cmd;
    logic    idx_bad;
    logic    rise_tick;
    logic    fall_tick;

    generate
        if (IDX_W > 5) begin : g_wide_idx
            assign idx_bad = |reg_idx[IDX_W-1:5];
        end else begin : g_narrow_idx
            assign idx_bad = 1'b0;
        end
    endgenerate

    assign cmd  = '{wr: wr, phy: phy_addr, regi: reg_idx[4:0], wdata: wdata};
    assign busy = (state != ST_IDLE);

    mdio_tick_gen #(.MDC_HALF(MDC_HALF)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .run       (busy),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdc       (mdc)
    );

    mdio_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .cmd       (cmd),
        .idx_bad   (idx_bad),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdi       (mdio_i),
        .state     (state),
        .done      (done),
        .rdata     (rdata),
        .mdo       (mdio_o),
        .oe        (mdio_oe)
    );

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe));
    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    a_r9_fall_gives_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
    a_r7_data_hold_high: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
    a_r8_refused: assert property (@(posedge clk) disable iff (rst)
        (req && !busy && idx_bad) |=> (done && !busy && !mdc));
    a_r2_mdc_needs_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(mdc) |-> busy);

endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [7:0]  reg_idx = '0;
    logic [15:0] wdata = '0;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic [15:0] rdata;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic        rec_oe [128];
    logic        rec_do [128];
    int          nrec = 0;
    int          perr = 0;
    int          last_rise = -1;
    logic [18:0] pat = '0;
    int          k = 0;

    mdio_master #(.MDC_HALF(HALF), .IDX_W(8)) dut (
        .clk(clk), .rst(rst), .req(req), .wr(wr), .phy_addr(phy_addr),
        .reg_idx(reg_idx), .wdata(wdata), .busy(busy), .done(done),
        .rdata(rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    always @(posedge mdc) begin
        if (nrec < 128) begin
            rec_oe[nrec] = mdio_oe;
            rec_do[nrec] = mdio_o;
            nrec++;
        end
        if (last_rise >= 0 && cyc - last_rise != 2 * HALF) perr++;
        last_rise = cyc;
        if (!mdio_oe) begin
            k++;
            if (k < 19) mdio_i = pat[18-k];
        end
    end

    always @(negedge mdc) if (cyc - last_rise != HALF) perr++;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_frame(bit w, logic [4:0] p, logic [4:0] r, logic [15:0] d);
        if (w) return {2'b01, 2'b01, p, r, 2'b10, d};
        else   return {2'b11, 2'b01, 2'b10, p, r, 16'h0};
    endfunction

    task automatic txn(input bit w, input logic [4:0] p, input logic [7:0] r,
                       input logic [15:0] d, input logic [18:0] pt, input bit inject);
        logic [31:0] fr;
        int hb, rel, nb, n, bad, ndone;
        logic [31:0] bad_at;
        hb = w ? 32 : 16;
        rel = w ? 2 : 19;
        nb = 33 + hb + rel;
        fr = exp_frame(w, p, r[4:0], d);
        pat = pt; k = 0; mdio_i = pt[18]; nrec = 0; perr = 0; last_rise = -1;
        @(negedge clk);
        req = 1'b1; wr = w; phy_addr = p; reg_idx = r; wdata = d;
        @(negedge clk);
        req = 1'b0;
        chk(busy === 1'b1, "R9", "busy after accept", {31'd0, busy}, 32'd1);
        n = 0; ndone = 0;
        while (done !== 1'b1 && n < 4000) begin
            if (inject && n == 50) begin
                req = 1'b1; wr = ~w; phy_addr = ~p; reg_idx = 8'h03; wdata = ~d;
            end else req = 1'b0;
            @(negedge clk);
            n++;
        end
        req = 1'b0;
        chk(n == nb * 2 * HALF, w ? "R6" : "R4", "done cycle", n, nb * 2 * HALF);
        chk(busy === 1'b0, "R9", "busy low at done", {31'd0, busy}, 32'd0);
        chk(nrec == nb, w ? "R6" : "R4", "bit periods", nrec, nb);
        bad = 0; bad_at = 0;
        for (int i = 0; i < 33; i++)
            if (!(rec_oe[i] === 1'b1 && rec_do[i] === 1'b1)) begin bad++; bad_at = i; end
        chk(bad == 0, "R2", "preamble bad bits (last idx)", bad_at, 32'd0);
        bad = 0; bad_at = 0;
        for (int i = 0; i < hb; i++)
            if (!(rec_oe[33+i] === 1'b1 && rec_do[33+i] === fr[31-i])) begin bad++; bad_at = i; end
        chk(bad == 0, w ? "R5" : "R3", "frame bits (last bad idx)", bad_at, 32'd0);
        bad = 0;
        for (int i = 0; i < rel; i++)
            if (rec_oe[33+hb+i] !== 1'b0) bad++;
        chk(bad == 0, w ? "R6" : "R4", "released periods driven", bad, 0);
        chk(perr == 0, "R7", "mdc phase length errors", perr, 0);
        if (!w) chk(rdata === pt[16:1], "R4", "rdata", {16'd0, rdata}, {16'd0, pt[16:1]});
        @(negedge clk);
        ndone = done;
        chk(ndone == 0 && busy === 1'b0, "R10", "no second done/busy", {busy, done}, 0);
        chk(mdc === 1'b0 && mdio_oe === 1'b0, "R1", "quiet after txn", {mdc, mdio_oe}, 0);
    endtask

    task automatic refuse(input bit w, input logic [7:0] r);
        int rises;
        logic [15:0] prev;
        prev = rdata;
        nrec = 0;
        @(negedge clk);
        req = 1'b1; wr = w; reg_idx = r; phy_addr = 5'd7; wdata = 16'h1234;
        @(negedge clk);
        req = 1'b0;
        chk(done === 1'b1 && busy === 1'b0, "R8", "refused done/busy", {busy, done}, 32'd1);
        chk(rdata === (w ? prev : 16'hFFFF), "R8", "refused rdata", rdata, w ? prev : 16'hFFFF);
        repeat (20) @(negedge clk);
        rises = nrec;
        chk(rises == 0, "R8", "mdc edges on refused", rises, 0);
    endtask

    initial begin : wd
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog timeout actual=%0d expected=<150000", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !mdc && !mdio_oe, "R1", "reset state", {busy, done, mdc, mdio_oe}, 0);
        txn(1'b0, 5'h1F, 8'h00, 16'h0, 19'h7FFFF, 1'b0);
        txn(1'b0, 5'h00, 8'h1F, 16'h0, 19'h00000, 1'b0);
        txn(1'b1, 5'h15, 8'h0A, 16'hA55A, 19'h0, 1'b0);
        txn(1'b1, 5'h00, 8'h1F, 16'hFFFF, 19'h0, 1'b0);
        txn(1'b0, 5'h03, 8'h04, 16'h0, 19'h5A5A5, 1'b1);
        txn(1'b1, 5'h0C, 8'h11, 16'h0F0F, 19'h0, 1'b1);
        refuse(1'b0, 8'h20);
        refuse(1'b1, 8'hE1);
        for (int t = 0; t < 10; t++)
            txn(1'($urandom), 5'($urandom), {3'b000, 5'($urandom)}, 16'($urandom), 19'($urandom), 1'b0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule